// File: doc/BRIEF.md
# Paged Parallel EEPROM Write Engine

This block is the device side of a byte-wide parallel EEPROM, built for a chip that must present an EEPROM-like bus to an external host. The chip enable, output enable and write enable strobes, the 15-bit address and the 8-bit bidirectional data bus are all sampled by a fast system clock. A host reads the block like a static RAM. A host writes to it by loading between one and 64 bytes of a single 64-byte page into an internal buffer.

When no new byte arrives within a load window, the page is closed. A programming timer then runs. After it expires, only the byte positions that were loaded are copied into the on-chip array. While the page is busy, any read returns a polling byte whose top bit is the inverse of the last byte loaded. This lets the host detect when the write has finished.

The array holds 2^ARRAY_AW bytes and is indexed by the low address bits, so it repeats across the 15-bit address space. Both timers are given in microseconds and converted to clock cycles from the clock-frequency parameter, so a bench can scale them down.

Top module: `eeprom_page_writer`

## Requirements
- R1: When ce_n=0, oe_n=0 and we_n=1 and the block is not busy, data_io returns the array byte at the address within 6 clock cycles. In every other strobe state, data_io is high impedance.
- R2: A byte is written only while ce_n=0 and we_n=0 with oe_n=1. A strobe with oe_n=0 loads nothing and leaves the array unchanged.
- R3: The address of a byte is the one present when the later of the ce_n and we_n falling edges occurs.
- R4: The data of a byte is the one present when the earlier of the ce_n and we_n rising edges occurs.
- R5: Address bits 14..6 choose the page and bits 5..0 the byte within it. One load holds all 64 slots. The array index is the low ARRAY_AW address bits, so addresses 2^ARRAY_AW apart alias.
- R6: A load stays open while each byte follows the previous one within WIN_US. Once WIN_US passes without a byte, the load closes and programming starts.
- R7: Bytes may be loaded in any order, and a later byte to the same slot replaces the earlier one. Only slots loaded in the current load change in the array; all other bytes keep their values.
- R8: During programming, a read at any address returns the last loaded byte with bit 7 inverted. After programming ends, reads return the true array data.
- R9: Programming lasts PROG_US, plus one commit cycle per slot (64 cycles). The block then returns to idle and accepts a new load.
- R10: A byte whose page bits differ from the page of the open load is dropped. It raises page_err=1, which stays high until that load's programming ends and is 0 otherwise.
- R11: Write strobes arriving during programming are ignored: they neither change the array nor open a new load.
- R12: After reset the block is idle, page_err=0, no slot is loaded, and every array byte reads 8'hFF.

Verification assumptions and stimulus limits are covered in the Verification section.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address (page in 14..6, slot in 5..0) |
| data_io | inout | 8 | Bidirectional data bus |
| page_err | output | 1 | A byte of a foreign page was dropped during the open load |

## Verification
The assertions assume the host holds each strobe level, address and data for at least three clock cycles, so the two-stage synchronizer sees every edge in the order the host made them. They also assume a host never applies read and write strobes in the same cycle. The bench drives all bus changes on the falling clock edge and keeps every strobe phase several cycles long. It releases the data bus before any read, and keeps the gap between loaded bytes well under the scaled load window.

// File: rtl/eep_pkg.sv
// Shared types for the paged EEPROM write engine.
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_COMMIT
    } eng_state_e;
endpackage

// File: rtl/eep_strobe_sync.sv
// Brings the host's bus strobes, address and data into the clock domain.
// All pins pass through the same two-stage pipeline, so a strobe edge and the
// address/data seen with it stay aligned. Emits one-cycle pulses when a write
// strobe pair becomes active and when it ends, plus a level for read enable.
// Assumes every pin is held for at least three clock cycles.
module eep_strobe_sync #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_start,
    output logic              wr_end,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_s
);
    logic [2:0]        strb1_q, strb2_q;
    logic [ADDR_W-1:0] addr1_q;
    logic [DATA_W-1:0] data1_q;
    logic              act_q;
    logic              active;

    // Two-stage sampling of strobes, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb1_q <= 3'b111;
            strb2_q <= 3'b111;
            addr1_q <= '0;
            addr_s  <= '0;
            data1_q <= '0;
            data_s  <= '0;
        end else begin
            strb1_q <= {ce_n, oe_n, we_n};
            strb2_q <= strb1_q;
            addr1_q <= addr;
            addr_s  <= addr1_q;
            data1_q <= data_in;
            data_s  <= data1_q;
        end
    end

    // Write is active while both enables are low and output enable is high.
    assign active = !strb2_q[2] && strb2_q[1] && !strb2_q[0];
    assign rd_en  = !strb2_q[2] && !strb2_q[1] && strb2_q[0];

    // Remembers the previous write-active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= active;
    end

    assign wr_start = active && !act_q;
    assign wr_end   = !active && act_q;
endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: one data byte and one loaded flag per slot of a page.
// Stores a byte on request, offers one slot for the commit sweep, and
// drops all loaded flags on clear. Assumes store and clear never coincide.
module eep_page_buf #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [SLOT_W-1:0] store_slot,
    input  logic [DATA_W-1:0] store_byte,
    input  logic              clear,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_loaded
);
    localparam int SLOTS = 1 << SLOT_W;

    logic [DATA_W-1:0] bytes_q [SLOTS];
    logic [SLOTS-1:0]  loaded_q;

    // Holds loaded bytes; a repeated slot simply takes the newer byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= '0;
            for (int i = 0; i < SLOTS; i++) bytes_q[i] <= '0;
        end else if (clear) begin
            loaded_q <= '0;
        end else if (store) begin
            loaded_q[store_slot] <= 1'b1;
            bytes_q[store_slot]  <= store_byte;
        end
    end

    assign rd_byte   = bytes_q[rd_slot];
    assign rd_loaded = loaded_q[rd_slot];

    // R7
    store_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && clear));
endmodule

// File: rtl/eep_engine.sv
// Load/program sequencer with the storage array and read path.
// Opens a load on the first byte and checks later bytes against its page.
// Closes the load after a quiet window, then waits the programming time.
// Finally sweeps the buffer into the array one slot per cycle.
// Reads return the array when not busy and a polling byte when busy.
module eep_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 6,
    parameter int ARRAY_AW = 11,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_end,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] buf_byte,
    input  logic              buf_loaded,
    output logic              store,
    output logic [SLOT_W-1:0] store_slot,
    output logic              clear,
    output logic [SLOT_W-1:0] sweep_slot,
    output logic              rd_drive,
    output logic [DATA_W-1:0] rd_byte,
    output logic              page_err
);
    localparam int TAG_W  = ADDR_W - SLOT_W;
    localparam int DEPTH  = 1 << ARRAY_AW;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    eng_state_e        state_q;
    logic [ADDR_W-1:0] addr_lat_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] last_q;
    logic [WIN_W-1:0]  win_q;
    logic [PROG_W-1:0] prog_q;
    logic [SLOT_W-1:0] idx_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              tag_match, busy, mismatch;
    logic [ARRAY_AW-1:0] commit_idx, read_idx;

    assign tag_match  = addr_lat_q[ADDR_W-1:SLOT_W] == tag_q;
    assign store      = wr_end && (state_q == ST_IDLE || (state_q == ST_LOAD && tag_match));
    assign mismatch   = wr_end && state_q == ST_LOAD && !tag_match;
    assign store_slot = addr_lat_q[SLOT_W-1:0];
    assign clear      = state_q == ST_COMMIT && idx_q == SLOT_W'((1 << SLOT_W) - 1);
    assign sweep_slot = idx_q;
    assign busy       = state_q == ST_PROG || state_q == ST_COMMIT;
    assign commit_idx = ARRAY_AW'({tag_q, idx_q});
    assign read_idx   = ARRAY_AW'(addr_s);

    // Latches the address when a write strobe pair becomes active.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_lat_q <= '0;
        else if (wr_start) addr_lat_q <= addr_s;
    end

    // Sequencer: load window, programming timer, commit sweep, error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tag_q    <= '0;
            last_q   <= '0;
            win_q    <= '0;
            prog_q   <= '0;
            idx_q    <= '0;
            page_err <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (store) begin
                    state_q <= ST_LOAD;
                    tag_q   <= addr_lat_q[ADDR_W-1:SLOT_W];
                    last_q  <= data_s;
                    win_q   <= '0;
                end
                ST_LOAD: begin
                    if (mismatch) page_err <= 1'b1;
                    if (store) begin
                        last_q <= data_s;
                        win_q  <= '0;
                    end else if (win_q == WIN_W'(WIN_CYC - 1)) begin
                        state_q <= ST_PROG;
                        prog_q  <= '0;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_PROG: if (prog_q == PROG_W'(PROG_CYC - 1)) begin
                    state_q <= ST_COMMIT;
                    idx_q   <= '0;
                end else begin
                    prog_q <= prog_q + 1'b1;
                end
                default: if (clear) begin
                    state_q  <= ST_IDLE;
                    page_err <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            endcase
        end
    end

    // Storage array: erased at reset, written only for loaded slots in the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (state_q == ST_COMMIT && buf_loaded) begin
            mem[commit_idx] <= buf_byte;
        end
    end

    // Registered read path with polling substitution while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_drive <= 1'b0;
            rd_byte  <= '0;
        end else begin
            rd_drive <= rd_en;
            rd_byte  <= busy ? {~last_q[DATA_W-1], last_q[DATA_W-2:0]} : mem[read_idx];
        end
    end

    // R6
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |-> win_q < WIN_W'(WIN_CYC));
    // R10
    err_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_err) |-> $past(state_q) == ST_LOAD);
    // R11
    prog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> ($stable(tag_q) && $stable(last_q)));
    // R9
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == ST_IDLE && !page_err));
endmodule

// File: rtl/eeprom_page_writer.sv
// Top of the paged EEPROM write engine: synchronizer, page buffer and
// sequencer, with the tri-state driver on the shared data bus.
// Assumes ADDR_W = TAG + SLOT_W and ARRAY_AW > SLOT_W.
module eeprom_page_writer #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int WIN_US   = 150,
    parameter int PROG_US  = 3000,
    parameter int ARRAY_AW = 11,
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] data_io,
    output logic              page_err
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int WIN_CYC    = CYC_PER_US * WIN_US;
    localparam int PROG_CYC   = CYC_PER_US * PROG_US;

    logic              wr_start, wr_end, rd_en, store, clear, buf_loaded, rd_drive;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s, buf_byte, rd_byte;
    logic [SLOT_W-1:0] store_slot, sweep_slot;

    assign data_io = rd_drive ? rd_byte : {DATA_W{1'bz}};

    eep_strobe_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_io), .wr_start(wr_start), .wr_end(wr_end),
        .rd_en(rd_en), .addr_s(addr_s), .data_s(data_s)
    );

    eep_page_buf #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .store(store), .store_slot(store_slot),
        .store_byte(data_s), .clear(clear), .rd_slot(sweep_slot),
        .rd_byte(buf_byte), .rd_loaded(buf_loaded)
    );

    eep_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .ARRAY_AW(ARRAY_AW),
        .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
        .rd_en(rd_en), .addr_s(addr_s), .data_s(data_s), .buf_byte(buf_byte),
        .buf_loaded(buf_loaded), .store(store), .store_slot(store_slot),
        .clear(clear), .sweep_slot(sweep_slot), .rd_drive(rd_drive),
        .rd_byte(rd_byte), .page_err(page_err)
    );

    // R1
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(oe_n, 3) == 1'b0);
endmodule

// File: tb/eeprom_page_writer_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module eeprom_page_writer_tb;
    localparam int WIN  = 100;   // 2 us at 50 MHz
    localparam int PROG = 200;   // 4 us at 50 MHz
    localparam int DONE_WAIT = WIN + PROG + 64 + 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  tb_d = '0;
    logic        tb_drv = 1'b0;
    wire  [7:0]  data_io;
    logic        page_err;
    int          checks = 0, errors = 0;

    assign data_io = tb_drv ? tb_d : 8'bz;
    always #10 clk = ~clk;

    eeprom_page_writer #(.CLK_HZ(50_000_000), .WIN_US(2), .PROG_US(4), .ARRAY_AW(11)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_io(data_io), .page_err(page_err)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [14:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; tb_drv = 1'b0; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        cyc(6);
        v = data_io;
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(5);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; tb_d = d; tb_drv = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(3); we_n = 1'b0;
        cyc(4); we_n = 1'b1;
        cyc(3); ce_n = 1'b1; tb_drv = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R12 page_err", {7'b0, page_err}, 8'h00);
        chk("R1 idle bus z", data_io, 8'hzz);
        rd(15'h0000, v); chk("R12 erased", v, 8'hFF);
        rd(15'h07FF, v); chk("R12 erased top", v, 8'hFF);
        chk("R1 released z", data_io, 8'hzz);
        ce_n = 1'b0; cyc(6);
        chk("R1 oe high z", data_io, 8'hzz);
        ce_n = 1'b1; cyc(3);
    endtask

    task automatic t_page();
        logic [7:0] v;
        wr(15'h0045, 8'h22);
        wr(15'h0040, 8'h11);
        wr(15'h0041, 8'h33);
        rd(15'h0040, v); chk("R6 load still open reads array", v, 8'hFF);
        wr(15'h0045, 8'h44);
        cyc(WIN + 20);
        rd(15'h0123, v); chk("R8 poll inverted bit7", v, 8'hC4);
        cyc(PROG - 60);
        rd(15'h0040, v); chk("R9 still busy near end", v, 8'hC4);
        cyc(DONE_WAIT - PROG);
        rd(15'h0040, v); chk("R7 slot0", v, 8'h11);
        rd(15'h0041, v); chk("R7 slot1", v, 8'h33);
        rd(15'h0045, v); chk("R7 overwrite kept", v, 8'h44);
        rd(15'h0042, v); chk("R7 unloaded slot", v, 8'hFF);
        rd(15'h0080, v); chk("R7 other page", v, 8'hFF);
    endtask

    task automatic t_oe_block();
        logic [7:0] v;
        @(negedge clk);
        addr = 15'h00C0; tb_d = 8'h5F; tb_drv = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(3); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(3);
        ce_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0; cyc(3);
        rd(15'h00C0, v); chk("R2 no load opened", v, 8'hFF);
        cyc(DONE_WAIT);
        rd(15'h00C0, v); chk("R2 array unchanged", v, 8'hFF);
    endtask

    task automatic t_edges();
        logic [7:0] v;
        @(negedge clk);
        oe_n = 1'b1; tb_drv = 1'b1; tb_d = 8'h5A; addr = 15'h0108;
        we_n = 1'b0; cyc(3);
        addr = 15'h0100; cyc(3);
        ce_n = 1'b0; cyc(4);
        we_n = 1'b1; cyc(3);
        tb_d = 8'hA5; cyc(3);
        ce_n = 1'b1; cyc(3); tb_drv = 1'b0;
        cyc(DONE_WAIT);
        rd(15'h0100, v); chk("R3 later fall address / R4 early rise data", v, 8'h5A);
        rd(15'h0108, v); chk("R3 early address unused", v, 8'hFF);
    endtask

    task automatic t_mismatch();
        logic [7:0] v;
        wr(15'h0200, 8'h01);
        wr(15'h0300, 8'h02);
        cyc(2);
        chk("R10 flag raised", {7'b0, page_err}, 8'h01);
        cyc(DONE_WAIT);
        chk("R10 flag cleared", {7'b0, page_err}, 8'h00);
        rd(15'h0200, v); chk("R10 own page written", v, 8'h01);
        rd(15'h0300, v); chk("R10 foreign byte dropped", v, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        wr(15'h0400, 8'h77);
        cyc(WIN + 20);
        wr(15'h0401, 8'h88);
        wr(15'h0400, 8'h99);
        rd(15'h0401, v); chk("R8 poll any address", v, 8'hF7);
        cyc(DONE_WAIT);
        rd(15'h0400, v); chk("R11 first byte kept", v, 8'h77);
        rd(15'h0401, v); chk("R11 busy write ignored", v, 8'hFF);
        cyc(DONE_WAIT);
        rd(15'h0401, v); chk("R11 no late load", v, 8'hFF);
    endtask

    task automatic t_full_page();
        logic [7:0] v;
        for (int s = 63; s >= 0; s--) wr(15'h0780 + 15'(s), 8'(s) ^ 8'h3C);
        cyc(DONE_WAIT);
        for (int s = 0; s < 64; s++) begin
            rd(15'h0780 + 15'(s), v);
            chk("R5 full page slot", v, 8'(s) ^ 8'h3C);
        end
        rd(15'h0F85, v); chk("R5 alias", v, 8'h05 ^ 8'h3C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_page();
        t_oe_block();
        t_edges();
        t_mismatch();
        t_busy_ignore();
        t_full_page();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule